// File: doc/BRIEF.md
# DMA Channel Service Controller

This block is the control core of a single DMA channel. A peripheral raises a request line. The channel synchronizes that line, acknowledges it, and then asks for the system bus. Once the bus is granted, the channel moves data by reading from a source address and writing the same data to a destination address. Each such read-then-write move, or a burst of four of them, is one atomic operation. A 20-bit transfer counter is loaded at the start of a block. The counter is decremented once per atomic operation.

The channel has two service modes:

- **Whole mode:** one request serves the entire block. Acknowledge and bus request stay high until the counter reaches zero.
- **Single mode:** each request is served by exactly one atomic operation. Acknowledge drops after that operation. The counter and both address pointers carry over to the next request.

In both modes, a one-cycle interrupt pulse marks the terminal count, provided the interrupt enable is set.

Source and destination pointers advance by the data size after each unit. The data size is byte, halfword or word.

Top module: `dma_svc_ctrl`

## Requirements
- R1: While reset is active, and directly after it, `dack_o`, `irq_o`, `bus_req_o` and `mem_req_o` are low.
- R2: `dreq_i` passes through two synchronizing flops. After `dreq_i` is first sampled high on a rising edge, `dack_o` is still low after the next edge and is high after the edge following that.
- R3: `bus_req_o` is high only while `dack_o` is high, and it falls in the same cycle as `dack_o`. `mem_req_o` is raised only while both are high. An atomic operation starts only in a cycle where `bus_gnt_i` is high.
- R4: An atomic unit is a read at the source pointer followed by a write of the returned data at the destination pointer. `cfg_size_i` encodes 0 as byte, 1 as halfword and 2 as word, and each pointer advances by 1, 2 or 4 after its access. The value of `mem_size_o` equals the configured size.
- R5: With `cfg_burst_i` = 1, one atomic operation is 4 consecutive read/write units. With `cfg_burst_i` = 0, it is 1 unit.
- R6: The counter is loaded from `cfg_count_i`, and the pointers from `cfg_src_i`/`cfg_dst_i`, only when a request is served while the counter is zero. The counter decrements by one per atomic operation.
- R7: In whole mode (`cfg_whole_i` = 1), a single request performs all counted atomic operations, with `dack_o` falling exactly once, after the last one.
- R8: In single mode (`cfg_whole_i` = 0), each request performs exactly one atomic operation, after which `dack_o` falls.
- R9: `irq_o` is a one-cycle pulse, raised in the cycle `dack_o` falls after the counter reaches zero, and only if `cfg_irq_en_i` = 1. It is never raised at any other time, in either mode.
- R10: A count field of zero is served as a count of one.
- R11: In single mode, consecutive requests within one block continue from the pointers where the previous request left them.
- R12: A memory access is held, with address, direction and write data unchanged, until `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dreq_i | input | 1 | Asynchronous service request |
| dack_o | output | 1 | Service acknowledge |
| irq_o | output | 1 | Terminal-count interrupt pulse |
| bus_req_o | output | 1 | System bus request |
| bus_gnt_i | input | 1 | System bus grant |
| cfg_count_i | input | CNT_W (20) | Transfer count field |
| cfg_whole_i | input | 1 | 1 = whole mode, 0 = single mode |
| cfg_burst_i | input | 1 | 1 = burst of 4 units per atomic operation |
| cfg_size_i | input | 2 | Data size: 0 byte, 1 halfword, 2 word |
| cfg_irq_en_i | input | 1 | Terminal-count interrupt enable |
| cfg_src_i | input | ADDR_W (32) | Source base address |
| cfg_dst_i | input | ADDR_W (32) | Destination base address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W (32) | Memory access address |
| mem_size_o | output | 2 | Memory access size |
| mem_wdata_o | output | DATA_W (32) | Write data |
| mem_rdata_i | input | DATA_W (32) | Read data |
| mem_ready_i | input | 1 | Access completes in this cycle |

## Verification
The bench builds the block with its default parameters: a 20-bit counter, 32-bit addresses and data, bursts of 4, and two synchronizer stages.

It sweeps every combination of the following settings:

- service mode;
- burst or single transfer;
- all three data sizes;
- interrupt enable;
- counts 0 through 3.

This brings the count-of-zero case, multi-request single-mode blocks and pointer carry-over all within reach. A pseudo-random ready signal inserts wait states into every access. Read data is a known function of the address, so every write's address and data can be predicted arithmetically.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_XFER  = 2'd2
  } main_st_e;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_RD   = 2'd1,
    E_WR   = 2'd2
  } eng_st_e;

  // size code -> byte step: 0 byte, 1 halfword, else word
  function automatic logic [3:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 4'd1;
      2'd1:    size_step = 4'd2;
      default: size_step = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic req_o
);

  logic [STAGES-1:0] sq;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq[i] <= 1'b0;
        else if (i == 0) sq[i] <= req_i;
        else sq[i] <= sq[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign req_o = sq[STAGES-1];

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_svc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [1:0]        size_i,
  input  logic              burst_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);

  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  eng_st_e           st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        size_q;
  logic              burst_q;
  logic [ADDR_W-1:0] step;
  logic              last_unit;

  assign step      = ADDR_W'(size_step(size_q));
  assign last_unit = !burst_q || (beat_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      beat_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
      size_q  <= 2'd0;
      burst_q <= 1'b0;
    end else begin
      if (load_i) begin
        src_q <= src_base_i;
        dst_q <= dst_base_i;
      end
      case (st_q)
        E_IDLE: if (start_i) begin
          st_q    <= E_RD;
          beat_q  <= '0;
          size_q  <= size_i;
          burst_q <= burst_i;
        end
        E_RD: if (mem_ready_i) begin
          data_q <= mem_rdata_i;
          src_q  <= src_q + step;
          st_q   <= E_WR;
        end
        E_WR: if (mem_ready_i) begin
          dst_q <= dst_q + step;
          if (last_unit) st_q <= E_IDLE;
          else begin
            beat_q <= beat_q + 1'b1;
            st_q   <= E_RD;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != E_IDLE);
  assign done_o      = (st_q == E_WR) && mem_ready_i && last_unit;
  assign mem_req_o   = (st_q == E_RD) || (st_q == E_WR);
  assign mem_we_o    = (st_q == E_WR);
  assign mem_addr_o  = (st_q == E_WR) ? dst_q : src_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = data_q;

  AST_WDATA_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> mem_wdata_o == $past(mem_rdata_i)); // R4

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o))); // R12

  AST_NO_LOAD_MIDOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R6

endmodule

// File: rtl/dma_svc_fsm.sv
module dma_svc_fsm
  import dma_svc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_sync_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             cfg_whole_i,
  input  logic             cfg_irq_en_i,
  input  logic             bus_gnt_i,
  input  logic             eng_busy_i,
  input  logic             eng_done_i,
  output logic             ack_o,
  output logic             bus_req_o,
  output logic             irq_o,
  output logic             load_o,
  output logic             start_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  main_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             whole_q, irq_en_q, irq_q;
  logic             fresh, cnt_last, term;

  assign fresh    = (cnt_q == '0);
  assign cnt_last = (cnt_q == ONE);
  assign term     = (st_q == M_XFER) && eng_done_i && cnt_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= M_IDLE;
      cnt_q    <= '0;
      whole_q  <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= term && irq_en_q;
      case (st_q)
        M_IDLE: if (req_sync_i) st_q <= M_SETUP;
        M_SETUP: begin
          whole_q  <= cfg_whole_i;
          irq_en_q <= cfg_irq_en_i;
          // reload only at the start of a block; zero count runs once
          if (fresh) cnt_q <= (cfg_count_i == '0) ? ONE : cfg_count_i;
          st_q <= M_XFER;
        end
        M_XFER: if (eng_done_i) begin
          cnt_q <= cnt_q - ONE;
          if (!whole_q || cnt_last) st_q <= M_IDLE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign ack_o     = (st_q != M_IDLE);
  assign bus_req_o = (st_q == M_XFER);
  assign irq_o     = irq_q;
  assign load_o    = (st_q == M_SETUP) && fresh;
  assign start_o   = (st_q == M_XFER) && bus_gnt_i && !eng_busy_i;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9

  AST_IRQ_AT_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!ack_o && $past(ack_o))); // R9

  AST_CNT_LIVE_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_XFER) |-> (cnt_q != '0)); // R6

  AST_SINGLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == M_XFER) && eng_done_i && !whole_q) |=> !ack_o); // R8

  AST_WHOLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == M_XFER) && eng_done_i && whole_q && !cnt_last) |=> ack_o); // R7

  AST_START_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (bus_gnt_i && bus_req_o)); // R3

endmodule

// File: rtl/dma_svc_ctrl.sv
module dma_svc_ctrl #(
  parameter int CNT_W       = 20,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dreq_i,
  output logic              dack_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic              cfg_whole_i,
  input  logic              cfg_burst_i,
  input  logic [1:0]        cfg_size_i,
  input  logic              cfg_irq_en_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);

  logic req_sync, load, start, eng_busy, eng_done;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (dreq_i),
    .req_o  (req_sync)
  );

  dma_svc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_sync_i   (req_sync),
    .cfg_count_i  (cfg_count_i),
    .cfg_whole_i  (cfg_whole_i),
    .cfg_irq_en_i (cfg_irq_en_i),
    .bus_gnt_i    (bus_gnt_i),
    .eng_busy_i   (eng_busy),
    .eng_done_i   (eng_done),
    .ack_o        (dack_o),
    .bus_req_o    (bus_req_o),
    .irq_o        (irq_o),
    .load_o       (load),
    .start_o      (start)
  );

  dma_xfer_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BURST_LEN (BURST_LEN)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .src_base_i  (cfg_src_i),
    .dst_base_i  (cfg_dst_i),
    .size_i      (cfg_size_i),
    .burst_i     (cfg_burst_i),
    .start_i     (start),
    .busy_o      (eng_busy),
    .done_o      (eng_done),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i)
  );

  AST_BREQ_UNDER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> dack_o); // R3

  AST_MEM_UNDER_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (bus_req_o && dack_o)); // R3

  AST_BREQ_DROPS_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> $fell(dack_o)); // R3

endmodule

// File: tb/dma_svc_ctrl_tb.sv
`timescale 1ns/1ps
module dma_svc_ctrl_tb_top;

  localparam int CNT_W = 20, ADDR_W = 32, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dreq = 1'b0, gnt = 1'b0, rdy = 1'b0;
  logic [CNT_W-1:0]  cnt_cfg = '0;
  logic whole = 1'b0, burst = 1'b0, irq_en = 1'b0;
  logic [1:0] size = 2'd0;
  logic [ADDR_W-1:0] src = '0, dst = '0;
  logic dack, irq, breq, mreq, mwe;
  logic [ADDR_W-1:0] maddr;
  logic [1:0] msize;
  logic [DATA_W-1:0] mwdata, mrdata;

  always #10 clk = ~clk; // 50 MHz

  dma_svc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .dack_o(dack), .irq_o(irq),
    .bus_req_o(breq), .bus_gnt_i(gnt), .cfg_count_i(cnt_cfg), .cfg_whole_i(whole),
    .cfg_burst_i(burst), .cfg_size_i(size), .cfg_irq_en_i(irq_en),
    .cfg_src_i(src), .cfg_dst_i(dst), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_size_o(msize), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_ready_i(rdy)
  );

  // read data is a known function of the address
  assign mrdata = {maddr[15:0] ^ 16'h5a3c, ~maddr[15:0]};

  int n_vec = 0, n_bad = 0;
  int pairs = 0, irq_cyc = 0, ack_falls = 0;
  logic [ADDR_W-1:0] exp_src, exp_dst;
  logic [DATA_W-1:0] last_rd = '0;
  logic expect_wr = 1'b0, prev_ack = 1'b0;
  logic [7:0] lfsr = 8'h5b;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] stp(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // stimulus for grant and ready, off the edge
  always @(posedge clk) begin
    #5;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  <= lfsr[0] | lfsr[2];
    gnt  <= breq;
  end

  // monitor at falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (breq && !dack) chk(1'b0, "R3", breq, 0);
      if (mreq && !gnt) chk(1'b0, "R3", gnt, 1);
      if (irq) irq_cyc++;
      if (prev_ack && !dack) ack_falls++;
      prev_ack = dack;
      if (mreq && rdy) begin
        chk(msize == size, "R4", msize, size);
        if (!mwe) begin
          chk(!expect_wr, "R4", 1, 0);
          chk(maddr == exp_src, "R11", maddr, exp_src);
          exp_src = exp_src + stp(size);
          last_rd = mrdata;
          expect_wr = 1'b1;
        end else begin
          chk(expect_wr, "R4", 0, 1);
          chk(maddr == exp_dst, "R4", maddr, exp_dst);
          chk(mwdata == last_rd, "R4", mwdata, last_rd);
          exp_dst = exp_dst + stp(size);
          expect_wr = 1'b0;
          pairs++;
        end
      end
    end
  end

  task automatic serve_one();
    @(negedge clk); dreq = 1'b1;
    @(posedge clk); @(posedge clk); #3;
    chk(dack == 1'b0, "R2", dack, 0);
    @(posedge clk); #3;
    chk(dack == 1'b1, "R2", dack, 1);
    dreq = 1'b0;
    while (dack) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk(!dack && !irq && !breq && !mreq, "R1", {dack, irq, breq, mreq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dack && !irq && !breq && !mreq, "R1", {dack, irq, breq, mreq}, 0);
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 3; s++)
          for (int e = 0; e < 2; e++)
            for (int c = 0; c < 4; c++) begin
              int eff, nreq, beats, p0, i0, f0;
              whole = w[0]; burst = b[0]; size = s[1:0]; irq_en = e[0];
              cnt_cfg = CNT_W'(c);
              src = 32'h0001_0000 + 32'(n_vec * 16);
              dst = 32'h0008_0000 + 32'(c * 64 + s * 4);
              exp_src = src; exp_dst = dst;
              eff   = (c == 0) ? 1 : c;                 // R10
              nreq  = w ? 1 : eff;
              beats = b ? 4 : 1;
              for (int r = 0; r < nreq; r++) begin
                p0 = pairs; i0 = irq_cyc; f0 = ack_falls;
                serve_one();
                // R5 R7 R8: units per request
                chk(pairs - p0 == beats * (w ? eff : 1), w ? "R7" : "R8",
                    pairs - p0, beats * (w ? eff : 1));
                chk(ack_falls - f0 == 1, "R7", ack_falls - f0, 1);
                if (r < nreq - 1)
                  chk(irq_cyc == i0, "R6", irq_cyc - i0, 0); // no reload, no early irq
                else
                  chk(irq_cyc - i0 == e, (c == 0) ? "R10" : "R9", irq_cyc - i0, e);
              end
              // R5: total units across the block
              chk(exp_dst - dst == ADDR_W'(eff * beats) * stp(size[1:0]), "R5",
                  exp_dst - dst, eff * beats * stp(size[1:0]));
              chk(rdy || !mreq, "R12", mreq, 0);
            end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule